// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Buffer

This block holds a set of address translations and looks one up per accepted request. Each slot stores a virtual page number, a context number, a physical page number, a two-bit size code and a flag vector. A lookup presents a virtual page number, an access kind, a context selector, a user/kernel flag and a trap-level flag. Every slot is compared at the same time, each with the compare width its own size code sets. The response carries the physical address with access rights, or a miss, fault or protection outcome.

On a fault or protection outcome the block records a fault status word and a tag-access value. On a miss it records only the tag-access value. Slots are loaded through a write port by an external refill agent. A single demap pulse drops every slot that is not locked.

Lookup requests and responses use valid/ready handshakes. A request is taken on a clock edge where `lk_valid` and `lk_ready` are both high. Its response appears registered after that edge. `lk_ready` is high whenever the response register is empty or is being drained in the same cycle (`rs_ready` high). While `rs_valid` is high and `rs_ready` is low, the response is held unchanged and no new request is taken.

Top module: `msz_tlb`

## Requirements
- R1: Size code c (0..3) gives a page of 8 KB shifted left by 3*c (8K, 64K, 512K, 4M). The lowest 3*c bits of the request page number do not take part in that slot's tag compare.
- R2: On a hit with outcome OK, the physical address has its low 13 bits zero. Its page number takes the slot's page number above the lowest 3*c bits and the request's page number bits inside them. Data kinds give `rs_can_write` equal to the slot's writable flag and `rs_can_exec` 0. A fetch gives `rs_can_exec` 1 and `rs_can_write` 0.
- R3: A valid slot matches when its context equals the selected context or its global flag is set. Selector codes are 0 primary, 1 secondary, 2 or 3 context zero. Access kinds are 0 load, 1 store, 2 fetch, 3 no-fault load. A fetch uses the primary context when `lk_tl_nz` is 0 and context zero otherwise, whatever the selector.
- R4: When several slots match, the lowest index is reported and used.
- R5: Result codes are 0 OK, 1 MISS, 2 FAULT, 3 PROT. A user access to a privileged slot (flag bit 2) sets status bit 7. A no-fault load to a side-effect slot (flag bit 4) sets status bit 8. A load or store to a no-fault-only slot (flag bit 5) sets status bit 9. Any of these makes the result FAULT, and they may be set together. A fetch checks only the privilege rule. Any non-OK result gives no rights and no swap flag.
- R6: A store to a non-writable slot (flag bit 3 clear) with no R5 fault gives PROT. The status for it carries no fault-type bits.
- R7: On FAULT or PROT, the status word is written with these bits: bit 0 valid, bit 2 store, bit 3 no-fault load, bit 4 fetch, bits 6:5 context type (0 primary, 1 secondary, 2 zero) and the fault-type bits. On FAULT, PROT or MISS, tag access becomes {request page number, 13-bit context}. A MISS leaves the status word unchanged.
- R8: A FAULT or PROT that finds status bit 0 already set, with no `stat_ack` in that cycle, also sets bit 1 (overflow). `stat_ack` clears the status word unless a fault is recorded in the same cycle.
- R9: An OK lookup sets the slot's used flag (bit 7). `rs_first_use` reports that flag as clear before this lookup. A data hit on a slot with flag bit 6 set raises `rs_bswap`.
- R10: `demap_all` clears flag bit 0 of every slot whose lock flag (bit 8) is clear. Locked slots keep translating.
- R11: A response appears in the cycle after acceptance. It stays stable while `rs_ready` is low, and `lk_ready` is low in that time.
- R12: After reset no slot is valid, `rs_valid` is 0, and the status word and tag access are 0.
- R13: A slot write in the same cycle as an OK lookup of that slot wins. The used flag takes the written value, while the response reflects the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one slot |
| wr_idx | input | IDX_W | Slot index to write |
| wr_vpn | input | VA_W-13 | Virtual page number tag |
| wr_ctx | input | CTX_W | Context tag |
| wr_ppn | input | PA_W-13 | Physical page number |
| wr_size | input | 2 | Size code |
| wr_flags | input | 9 | Flags: 0 valid, 1 global, 2 priv, 3 writable, 4 side effect, 5 no-fault-only, 6 swap, 7 used, 8 lock |
| demap_all | input | 1 | Drop all unlocked slots |
| prim_ctx | input | CTX_W | Primary context |
| sec_ctx | input | CTX_W | Secondary context |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_vpn | input | VA_W-13 | Request virtual page number |
| lk_kind | input | 2 | Access kind |
| lk_sel | input | 2 | Context selector |
| lk_user | input | 1 | User-mode access |
| lk_tl_nz | input | 1 | Trap level above zero |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response consumed |
| rs_result | output | 2 | Result code |
| rs_pa | output | PA_W | Physical address |
| rs_can_write | output | 1 | Write permitted |
| rs_can_exec | output | 1 | Execute permitted |
| rs_bswap | output | 1 | Byte-swapped data |
| rs_first_use | output | 1 | Used flag was clear |
| rs_idx | output | IDX_W | Matching slot |
| stat_ack | input | 1 | Clear status word |
| fault_status | output | 10 | Fault status word |
| tag_access | output | VA_W | Tag-access value |

## Verification
A slot write can fall on the same edge as the used-flag update of an OK lookup that hits the same slot. The bench provokes this by writing a slot whose used flag is already set, with used clear, in the cycle its lookup is accepted. That response must report `rs_first_use` 0. A later lookup must report 1, which shows that the write won. The bench also provokes a fault in the cycle after `stat_ack`. It judges both orderings by the overflow bit of the status word.

// File: rtl/msz_tlb_pkg.sv
package msz_tlb_pkg;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2, ACC_NFLOAD = 2'd3} acc_kind_e;
  typedef enum logic [1:0] {SEL_PRIM = 2'd0, SEL_SEC = 2'd1, SEL_NUC = 2'd2, SEL_ZERO = 2'd3} ctx_sel_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_MISS = 2'd1, RES_FAULT = 2'd2, RES_PROT = 2'd3} result_e;

  localparam int PG_SHIFT = 13;
  localparam int SZ_STEP  = 3;
  localparam int LOW_MAX  = 3 * SZ_STEP;

  localparam int FLG_W    = 9;
  localparam int F_VALID  = 0;
  localparam int F_GLOBAL = 1;
  localparam int F_PRIV   = 2;
  localparam int F_WRITE  = 3;
  localparam int F_SIDE   = 4;
  localparam int F_NFO    = 5;
  localparam int F_SWAP   = 6;
  localparam int F_USED   = 7;
  localparam int F_LOCK   = 8;

  localparam int ST_W     = 10;
  localparam int S_VALID  = 0;
  localparam int S_OVF    = 1;
  localparam int S_STORE  = 2;
  localparam int S_NFL    = 3;
  localparam int S_FETCH  = 4;
  localparam int S_CT_LO  = 5;
  localparam int S_FPRIV  = 7;
  localparam int S_FNFE   = 8;
  localparam int S_FNFO   = 9;

  // bits of the page number that a size code removes from the compare
  function automatic logic [LOW_MAX-1:0] size_low_mask(input logic [1:0] sz);
    logic [LOW_MAX-1:0] m;
    m = '0;
    for (int b = 0; b < LOW_MAX; b++) begin
      if (b < SZ_STEP * int'(sz)) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/msz_tlb_store.sv
module msz_tlb_store
  import msz_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 51,
  parameter int PPN_W   = 28,
  parameter int CTX_W   = 13,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_size,
  input  logic [FLG_W-1:0] wr_flg,
  input  logic             demap,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [VPN_W-1:0] e_vpn  [ENTRIES],
  output logic [CTX_W-1:0] e_ctx  [ENTRIES],
  output logic [PPN_W-1:0] e_ppn  [ENTRIES],
  output logic [1:0]       e_size [ENTRIES],
  output logic [FLG_W-1:0] e_flg  [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             hit_wr;
    logic [FLG_W-1:0] flg_q;
    logic [VPN_W-1:0] vpn_q;
    logic [CTX_W-1:0] ctx_q;
    logic [PPN_W-1:0] ppn_q;
    logic [1:0]       size_q;

    assign hit_wr = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg_q <= '0;
      end else if (hit_wr) begin
        flg_q <= wr_flg;
      end else begin
        if (demap && !flg_q[F_LOCK]) flg_q[F_VALID] <= 1'b0;
        if (touch_en && (touch_idx == IDX_W'(g))) flg_q[F_USED] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        vpn_q  <= wr_vpn;
        ctx_q  <= wr_ctx;
        ppn_q  <= wr_ppn;
        size_q <= wr_size;
      end
    end

    assign e_vpn[g]  = vpn_q;
    assign e_ctx[g]  = ctx_q;
    assign e_ppn[g]  = ppn_q;
    assign e_size[g] = size_q;
    assign e_flg[g]  = flg_q;
  end
endmodule

// File: rtl/msz_tlb_match.sv
module msz_tlb_match
  import msz_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 51,
  parameter int CTX_W   = 13,
  parameter int IDX_W   = 6
) (
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  input  logic [VPN_W-1:0] e_vpn  [ENTRIES],
  input  logic [CTX_W-1:0] e_ctx  [ENTRIES],
  input  logic [1:0]       e_size [ENTRIES],
  input  logic [FLG_W-1:0] e_flg  [ENTRIES],
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] lm;
    logic             tag_eq;
    logic             ctx_ok;
    assign lm     = VPN_W'(size_low_mask(e_size[g]));
    assign tag_eq = ((q_vpn ^ e_vpn[g]) & ~lm) == '0;
    assign ctx_ok = e_flg[g][F_GLOBAL] || (e_ctx[g] == q_ctx);
    assign hit_vec[g] = e_flg[g][F_VALID] && tag_eq && ctx_ok;
  end

  // lowest index wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/msz_tlb_classify.sv
module msz_tlb_classify
  import msz_tlb_pkg::*;
(
  input  logic      hit,
  input  acc_kind_e kind,
  input  logic      user,
  input  logic      e_priv,
  input  logic      e_write,
  input  logic      e_side,
  input  logic      e_nfo,
  output result_e   res,
  output logic      ft_priv,
  output logic      ft_nfe,
  output logic      ft_nfo
);
  assign ft_priv = hit && user && e_priv;
  assign ft_nfe  = hit && (kind == ACC_NFLOAD) && e_side;
  assign ft_nfo  = hit && ((kind == ACC_LOAD) || (kind == ACC_STORE)) && e_nfo;

  always_comb begin
    if (!hit)                                  res = RES_MISS;
    else if (ft_priv || ft_nfe || ft_nfo)      res = RES_FAULT;
    else if ((kind == ACC_STORE) && !e_write)  res = RES_PROT;
    else                                       res = RES_OK;
  end
endmodule

// File: rtl/msz_tlb.sv
module msz_tlb
  import msz_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  parameter int IDX_W   = $clog2(ENTRIES),
  localparam int VPN_W  = VA_W - PG_SHIFT,
  localparam int PPN_W  = PA_W - PG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_size,
  input  logic [FLG_W-1:0] wr_flags,
  input  logic             demap_all,
  input  logic [CTX_W-1:0] prim_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_kind,
  input  logic [1:0]       lk_sel,
  input  logic             lk_user,
  input  logic             lk_tl_nz,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [1:0]       rs_result,
  output logic [PA_W-1:0]  rs_pa,
  output logic             rs_can_write,
  output logic             rs_can_exec,
  output logic             rs_bswap,
  output logic             rs_first_use,
  output logic [IDX_W-1:0] rs_idx,
  input  logic             stat_ack,
  output logic [ST_W-1:0]  fault_status,
  output logic [VA_W-1:0]  tag_access
);
  logic [VPN_W-1:0] e_vpn  [ENTRIES];
  logic [CTX_W-1:0] e_ctx  [ENTRIES];
  logic [PPN_W-1:0] e_ppn  [ENTRIES];
  logic [1:0]       e_size [ENTRIES];
  logic [FLG_W-1:0] e_flg  [ENTRIES];

  acc_kind_e        kind;
  ctx_sel_e         sel;
  logic [CTX_W-1:0] q_ctx;
  logic [1:0]       ctx_type;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [FLG_W-1:0] s_flg;
  logic [PPN_W-1:0] s_ppn;
  logic [PPN_W-1:0] s_lm;
  logic [PPN_W-1:0] pa_ppn;
  result_e          res;
  logic             ft_priv, ft_nfe, ft_nfo;
  logic             fire;
  logic             is_fetch;
  logic [ST_W-1:0]  st_new;

  assign kind     = acc_kind_e'(lk_kind);
  assign sel      = ctx_sel_e'(lk_sel);
  assign is_fetch = (kind == ACC_FETCH);

  // context and its status type
  always_comb begin
    if (is_fetch) begin
      q_ctx    = lk_tl_nz ? '0 : prim_ctx;
      ctx_type = lk_tl_nz ? 2'd2 : 2'd0;
    end else begin
      unique case (sel)
        SEL_PRIM: begin q_ctx = prim_ctx; ctx_type = 2'd0; end
        SEL_SEC:  begin q_ctx = sec_ctx;  ctx_type = 2'd1; end
        default:  begin q_ctx = '0;       ctx_type = 2'd2; end
      endcase
    end
  end

  msz_tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ctx(wr_ctx),
    .wr_ppn(wr_ppn), .wr_size(wr_size), .wr_flg(wr_flags),
    .demap(demap_all),
    .touch_en(fire && (res == RES_OK)), .touch_idx(hit_idx),
    .e_vpn(e_vpn), .e_ctx(e_ctx), .e_ppn(e_ppn), .e_size(e_size), .e_flg(e_flg)
  );

  msz_tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .IDX_W(IDX_W)
  ) u_match (
    .q_vpn(lk_vpn), .q_ctx(q_ctx),
    .e_vpn(e_vpn), .e_ctx(e_ctx), .e_size(e_size), .e_flg(e_flg),
    .hit(hit), .hit_idx(hit_idx)
  );

  assign s_flg  = e_flg[hit_idx];
  assign s_ppn  = e_ppn[hit_idx];
  assign s_lm   = PPN_W'(size_low_mask(e_size[hit_idx]));
  assign pa_ppn = (s_ppn & ~s_lm) | (lk_vpn[PPN_W-1:0] & s_lm);

  msz_tlb_classify u_class (
    .hit(hit), .kind(kind), .user(lk_user),
    .e_priv(s_flg[F_PRIV]), .e_write(s_flg[F_WRITE]),
    .e_side(s_flg[F_SIDE]), .e_nfo(s_flg[F_NFO]),
    .res(res), .ft_priv(ft_priv), .ft_nfe(ft_nfe), .ft_nfo(ft_nfo)
  );

  assign lk_ready = !rs_valid || rs_ready;
  assign fire     = lk_valid && lk_ready;

  always_comb begin
    st_new = '0;
    st_new[S_VALID]             = 1'b1;
    st_new[S_OVF]               = fault_status[S_VALID] && !stat_ack;
    st_new[S_STORE]             = (kind == ACC_STORE);
    st_new[S_NFL]               = (kind == ACC_NFLOAD);
    st_new[S_FETCH]             = is_fetch;
    st_new[S_CT_LO +: 2]        = ctx_type;
    st_new[S_FPRIV]             = ft_priv;
    st_new[S_FNFE]              = ft_nfe;
    st_new[S_FNFO]              = ft_nfo;
  end

  logic [PPN_W-1:0] rs_ppn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid     <= 1'b0;
      rs_result    <= RES_MISS;
      rs_ppn_q     <= '0;
      rs_can_write <= 1'b0;
      rs_can_exec  <= 1'b0;
      rs_bswap     <= 1'b0;
      rs_first_use <= 1'b0;
      rs_idx       <= '0;
    end else if (fire) begin
      rs_valid     <= 1'b1;
      rs_result    <= res;
      rs_ppn_q     <= (res == RES_OK) ? pa_ppn : '0;
      rs_can_write <= (res == RES_OK) && !is_fetch && s_flg[F_WRITE];
      rs_can_exec  <= (res == RES_OK) && is_fetch;
      rs_bswap     <= (res == RES_OK) && !is_fetch && s_flg[F_SWAP];
      rs_first_use <= (res == RES_OK) && !s_flg[F_USED];
      rs_idx       <= hit ? hit_idx : '0;
    end else if (rs_ready) begin
      rs_valid     <= 1'b0;
    end
  end

  assign rs_pa = {rs_ppn_q, PG_SHIFT'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_status <= '0;
      tag_access   <= '0;
    end else begin
      if (fire && (res != RES_OK)) tag_access <= {lk_vpn, PG_SHIFT'(q_ctx)};
      if (fire && ((res == RES_FAULT) || (res == RES_PROT))) fault_status <= st_new;
      else if (stat_ack) fault_status <= '0;
    end
  end
endmodule

// File: rtl/msz_tlb_chk.sv
module msz_tlb_chk #(
  parameter int PA_W  = 41,
  parameter int IDX_W = 6,
  parameter int ST_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic [1:0]       rs_result,
  input logic [PA_W-1:0]  rs_pa,
  input logic             rs_can_write,
  input logic             rs_can_exec,
  input logic             rs_bswap,
  input logic [IDX_W-1:0] rs_idx,
  input logic             stat_ack,
  input logic [ST_W-1:0]  fault_status
);
  assert_fault_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid && lk_ready) && rs_result[1]) |-> fault_status[0]);

  assert_miss_keeps_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid && lk_ready) && (rs_result == 2'd1) && !$past(stat_ack)) |-> $stable(fault_status));

  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid && lk_ready) && rs_result[1] && $past(fault_status[0]) && !$past(stat_ack))
      |-> fault_status[1]);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_result) && $stable(rs_pa) && $stable(rs_idx)));

  assert_no_rights_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && (rs_result != 2'd0)) |-> (!rs_can_write && !rs_can_exec && !rs_bswap));

  assert_exec_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_can_exec) |-> (!rs_can_write && !rs_bswap));
endmodule

bind msz_tlb msz_tlb_chk #(.PA_W(PA_W), .IDX_W(IDX_W), .ST_W(msz_tlb_pkg::ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_result(rs_result), .rs_pa(rs_pa),
  .rs_can_write(rs_can_write), .rs_can_exec(rs_can_exec), .rs_bswap(rs_bswap),
  .rs_idx(rs_idx), .stat_ack(stat_ack), .fault_status(fault_status)
);

// File: tb/msz_tlb_bench.sv
`timescale 1ns/1ps
module msz_tlb_bench;
  localparam int ENT = 64, VAW = 64, PAW = 41, CW = 13, IW = 6;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic wr_en = 0; logic [IW-1:0] wr_idx = 0; logic [50:0] wr_vpn = 0;
  logic [CW-1:0] wr_ctx = 0; logic [27:0] wr_ppn = 0; logic [1:0] wr_size = 0;
  logic [8:0] wr_flags = 0; logic demap_all = 0;
  logic [CW-1:0] prim_ctx = 13'd5, sec_ctx = 13'd9;
  logic lk_valid = 0, lk_ready; logic [50:0] lk_vpn = 0;
  logic [1:0] lk_kind = 0, lk_sel = 0; logic lk_user = 0, lk_tl_nz = 0;
  logic rs_valid, rs_ready = 1; logic [1:0] rs_result; logic [PAW-1:0] rs_pa;
  logic rs_can_write, rs_can_exec, rs_bswap, rs_first_use; logic [IW-1:0] rs_idx;
  logic stat_ack = 0; logic [9:0] fault_status; logic [VAW-1:0] tag_access;

  msz_tlb u_msz_tlb (.*);

  int total = 0, bad = 0; bit ended = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic put(input int idx, input longint va, input int ctx, input longint pa,
                     input int sz, input int fl);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_vpn = 51'(va >> 13); wr_ctx = CW'(ctx);
    wr_ppn = 28'(pa >> 13); wr_size = 2'(sz); wr_flags = 9'(fl);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic look(input int kind, input int sel, input bit user, input bit tl, input longint va);
    @(negedge clk);
    lk_valid = 1; lk_kind = 2'(kind); lk_sel = 2'(sel); lk_user = user; lk_tl_nz = tl;
    lk_vpn = 51'(va >> 13);
    @(negedge clk); lk_valid = 0;
  endtask

  typedef struct packed {
    logic [1:0]  kind; logic [1:0] sel; logic user; logic tl;
    logic [63:0] va; logic [1:0] res; logic [40:0] pa; logic cw; logic cx; logic [5:0] idx;
  } vec_t;

  // kind: 0 load 1 store 2 fetch 3 nf-load; sel: 0 prim 1 sec 2 nucleus; res: 0 OK 1 MISS 2 FAULT 3 PROT
  localparam vec_t VECS [14] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h0052_3456, 2'd0, 41'h0_8012_2000, 1'b1, 1'b0, 6'd0}, // R1 R2 4M page
    '{2'd0, 2'd0, 1'b1, 1'b0, 64'h1000_2abc, 2'd2, 41'h0,           1'b0, 1'b0, 6'd0}, // R5 priv
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h1000_2abc, 2'd0, 41'h1_2345_6000, 1'b1, 1'b0, 6'd1}, // R2 8K
    '{2'd0, 2'd1, 1'b0, 1'b0, 64'h2000_e123, 2'd0, 41'h0_4000_e000, 1'b0, 1'b0, 6'd2}, // R3 global, R1 64K
    '{2'd1, 2'd0, 1'b0, 1'b0, 64'h2000_e123, 2'd3, 41'h0,           1'b0, 1'b0, 6'd0}, // R6 prot
    '{2'd0, 2'd1, 1'b0, 1'b0, 64'h300c_1234, 2'd2, 41'h0,           1'b0, 1'b0, 6'd0}, // R5 nfo
    '{2'd3, 2'd1, 1'b0, 1'b0, 64'h300c_1234, 2'd2, 41'h0,           1'b0, 1'b0, 6'd0}, // R5 side effect
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h300c_1234, 2'd1, 41'h0,           1'b0, 1'b0, 6'd0}, // R3 ctx mismatch
    '{2'd2, 2'd0, 1'b0, 1'b1, 64'h5000_0010, 2'd0, 41'h0_0200_0000, 1'b0, 1'b1, 6'd4}, // R3 fetch tl>0
    '{2'd2, 2'd0, 1'b0, 1'b0, 64'h5000_0010, 2'd1, 41'h0,           1'b0, 1'b0, 6'd0}, // R3 fetch tl=0
    '{2'd0, 2'd2, 1'b0, 1'b0, 64'h5000_0010, 2'd0, 41'h0_0200_0000, 1'b0, 1'b0, 6'd4}, // R3 nucleus
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h6000_0100, 2'd0, 41'h0_0400_0000, 1'b0, 1'b0, 6'd5}, // R4 lowest
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h0080_0000, 2'd1, 41'h0,           1'b0, 1'b0, 6'd0}, // R1 past 4M
    '{2'd0, 2'd0, 1'b0, 1'b0, 64'h7000_0000, 2'd0, 41'h0_0500_0000, 1'b1, 1'b0, 6'd7}  // R9 swap slot
  };

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 act=%0d exp=%0d", 1, 0);
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(rs_valid == 0, "R12 rs_valid", rs_valid, 0);
    chk(fault_status == 0, "R12 status", fault_status, 0);
    chk(tag_access == 0, "R12 tag_access", tag_access, 0);
    chk(lk_ready == 1, "R12 lk_ready", lk_ready, 1);
    look(0, 0, 0, 0, 64'h0052_3456);
    chk(rs_result == 2'd1, "R12 empty miss", rs_result, 1);

    put(0, 64'h0040_0000, 5, 64'h0_8000_0000, 3, 9'h009);
    put(1, 64'h1000_2000, 5, 64'h1_2345_6000, 0, 9'h00D);
    put(2, 64'h2000_0000, 7, 64'h0_4000_0000, 1, 9'h003);
    put(3, 64'h3008_0000, 9, 64'h0_0100_0000, 2, 9'h03D);
    put(4, 64'h5000_0000, 0, 64'h0_0200_0000, 0, 9'h001);
    put(6, 64'h6000_0000, 5, 64'h0_0300_0000, 0, 9'h001);
    put(5, 64'h6000_0000, 5, 64'h0_0400_0000, 0, 9'h001);
    put(7, 64'h7000_0000, 5, 64'h0_0500_0000, 0, 9'h149);

    for (int i = 0; i < 14; i++) begin
      look(VECS[i].kind, VECS[i].sel, VECS[i].user, VECS[i].tl, VECS[i].va);
      chk(rs_result == VECS[i].res, $sformatf("R1/R2 vector %0d result", i), rs_result, VECS[i].res);
      chk(rs_pa == VECS[i].pa, $sformatf("R2 vector %0d pa", i), rs_pa, VECS[i].pa);
      chk(rs_can_write == VECS[i].cw && rs_can_exec == VECS[i].cx,
          $sformatf("R2 vector %0d rights", i), {rs_can_write, rs_can_exec}, {VECS[i].cw, VECS[i].cx});
      if (VECS[i].res == 2'd0)
        chk(rs_idx == VECS[i].idx, $sformatf("R4 vector %0d idx", i), rs_idx, VECS[i].idx);
    end

    // R9 used flag and swap
    look(0, 0, 0, 0, 64'h7000_0000);
    chk(rs_first_use == 0, "R9 second use", rs_first_use, 0);
    chk(rs_bswap == 1, "R9 bswap", rs_bswap, 1);

    // R13 write and used-flag update in one cycle
    @(negedge clk);
    lk_valid = 1; lk_kind = 0; lk_sel = 0; lk_user = 0; lk_tl_nz = 0; lk_vpn = 51'(64'h6000_0000 >> 13);
    wr_en = 1; wr_idx = 5; wr_vpn = 51'(64'h6000_0000 >> 13); wr_ctx = 5;
    wr_ppn = 28'(64'h0400_0000 >> 13); wr_size = 0; wr_flags = 9'h001;
    @(negedge clk); lk_valid = 0; wr_en = 0;
    chk(rs_first_use == 0, "R13 old contents", rs_first_use, 0);
    look(0, 0, 0, 0, 64'h6000_0000);
    chk(rs_first_use == 1, "R13 write wins", rs_first_use, 1);

    // R11 back-pressure
    @(negedge clk);
    rs_ready = 0; lk_valid = 1; lk_kind = 0; lk_sel = 0; lk_user = 0; lk_vpn = 51'(64'h1000_2000 >> 13);
    @(negedge clk);
    chk(rs_valid == 1 && lk_ready == 0, "R11 stall", {rs_valid, lk_ready}, 2'b10);
    lk_vpn = 51'(64'h2000_0000 >> 13);
    @(negedge clk);
    chk(rs_idx == 1 && rs_pa == 41'h1_2345_6000, "R11 held", rs_pa, 41'h1_2345_6000);
    lk_valid = 0; rs_ready = 1;
    @(negedge clk);
    chk(rs_valid == 0, "R11 drained", rs_valid, 0);

    // R7 R8 status and tag access
    @(negedge clk); stat_ack = 1; @(negedge clk); stat_ack = 0;
    chk(fault_status == 0, "R8 ack clears", fault_status, 0);
    look(0, 1, 1, 0, 64'h300c_1234);
    chk(fault_status == 10'h2A1, "R5 R7 combined fault", fault_status, 10'h2A1);
    chk(tag_access == 64'h300c_0009, "R7 tag access fault", tag_access, 64'h300c_0009);
    look(0, 0, 0, 0, 64'h0080_0000);
    chk(fault_status == 10'h2A1, "R7 miss keeps status", fault_status, 10'h2A1);
    chk(tag_access == 64'h0080_0005, "R7 tag access miss", tag_access, 64'h0080_0005);
    look(1, 0, 0, 0, 64'h2000_e123);
    chk(fault_status == 10'h007, "R6 R8 prot with overflow", fault_status, 10'h007);
    chk(tag_access == 64'h2000_e005, "R7 tag access prot", tag_access, 64'h2000_e005);

    // R10 demap keeps locked slots
    @(negedge clk); demap_all = 1; @(negedge clk); demap_all = 0;
    look(0, 0, 0, 0, 64'h0052_3456);
    chk(rs_result == 2'd1, "R10 unlocked dropped", rs_result, 1);
    look(0, 0, 0, 0, 64'h7000_0000);
    chk(rs_result == 2'd0 && rs_idx == 7, "R10 locked kept", rs_result, 0);

    wrap_up();
  end
endmodule